// File: doc/BRIEF.md
# Multi-Mode Self-Test Register

This block is a parameterised n-bit register that can be switched at run time between four roles used in built-in self-test. In its functional role it is an ordinary parallel-load register. In scan mode it forms a serial shift chain for loading and unloading state. In generate mode it runs as an autonomous pseudo-random pattern source. In compact mode it folds a parallel response word into its state on every clock, which leaves a signature.

Both self-test roles use a modular feedback structure. In this structure an XOR gate sits between two stages only where the fixed polynomial has a coefficient of one. Bits move from stage 0 toward stage n-1, and stage n-1 feeds back straight into stage 0. A synchronous seed load overrides every mode. This lets a controller start a pattern run or a signature run from a known state.

Top module: `bilbo_reg`

## Requirements
- R1: While `rst_n` is low, the register state is all zeros, and `par_out`, `signature` and `scan_out` are all zero.
- R2: When `seed_load` is high at a clock edge, the state after that edge equals `seed_value`, whatever the mode.
- R3: Mode code 2'b00 (load): the state after the edge equals `par_in`.
- R4: Mode code 2'b01 (scan): stage 0 takes `scan_in`, and every stage i>0 takes the old value of stage i-1. `scan_out` always shows stage WIDTH-1.
- R5: Mode code 2'b10 (generate), with a nonzero state: stage 0 takes the old stage WIDTH-1 (fb). Stage i>0 takes old stage i-1, XORed with fb where bit i of `TAPS` is 1. Bit i of `TAPS` is the coefficient of x^i, and bit 0 must be 1.
- R6: In generate mode, an all-zero state is replaced by `DEFAULT_SEED` at the next edge. After any generate-mode edge without a seed load, the state is nonzero.
- R7: With a primitive polynomial, generate mode revisits its start state after exactly 2^WIDTH-1 clocks and never passes through zero. This holds for degree 8 (`TAPS`=8'h1D, x^8+x^4+x^3+x^2+1) and degree 4 (`TAPS`=4'h3, x^4+x+1).
- R8: Mode code 2'b11 (compact): the state after the edge equals the generate-mode next state of R5, computed without the zero escape, XORed bit for bit with `par_in`.
- R9: Compaction is linear. From a zero start, the signature of the bitwise XOR of two response streams equals the XOR of the two signatures.
- R10: `par_out` and `signature` both show the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 load, 01 scan, 10 generate, 11 compact |
| seed_load | input | 1 | Synchronous seed override, highest priority |
| seed_value | input | WIDTH | State forced by seed_load |
| par_in | input | WIDTH | Parallel data (load) or response word (compact) |
| scan_in | input | 1 | Serial input into stage 0 |
| par_out | output | WIDTH | Register state |
| scan_out | output | 1 | Last stage, serial output |
| signature | output | WIDTH | Register state as signature |

## Verification
The embedded properties check the following on every clocked cycle:
- the seed override;
- the load, scan-shift and compaction step relations between consecutive states;
- the rule that generate mode never leaves the register at zero.

Only the bench scenarios can show the properties that span many cycles:
- the full 255-step and 15-step periods of the primitive polynomials;
- the linearity of signatures across separate compaction runs;
- the bit order seen serially at the scan output.

Random mode mixes compared against a bit-level model cover the transitions between modes.

// File: rtl/bilbo_reg.sv
module bilbo_reg #(
  parameter int               WIDTH        = 8,
  parameter logic [WIDTH-1:0] TAPS         = 'h1D,
  parameter logic [WIDTH-1:0] DEFAULT_SEED = 'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             seed_load,
  input  logic [WIDTH-1:0] seed_value,
  input  logic [WIDTH-1:0] par_in,
  input  logic             scan_in,
  output logic [WIDTH-1:0] par_out,
  output logic             scan_out,
  output logic [WIDTH-1:0] signature
);

  localparam logic [1:0] M_LOAD = 2'b00;
  localparam logic [1:0] M_SCAN = 2'b01;
  localparam logic [1:0] M_GEN  = 2'b10;
  localparam logic [1:0] M_COMP = 2'b11;

  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] lfsr_nxt;
  logic [WIDTH-1:0] state_d;
  logic             fb;

  assign fb          = state_q[WIDTH-1];
  assign lfsr_nxt[0] = fb;

  for (genvar i = 1; i < WIDTH; i++) begin : g_stage
    if (TAPS[i]) begin : g_tap
      assign lfsr_nxt[i] = state_q[i-1] ^ fb;
    end else begin : g_wire
      assign lfsr_nxt[i] = state_q[i-1];
    end
  end

  always_comb begin
    if (seed_load) begin
      state_d = seed_value;
    end else begin
      unique case (mode)
        M_LOAD:  state_d = par_in;
        M_SCAN:  state_d = {state_q[WIDTH-2:0], scan_in};
        M_GEN:   state_d = (state_q == '0) ? DEFAULT_SEED : lfsr_nxt;
        default: state_d = lfsr_nxt ^ par_in;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  assign par_out   = state_q;
  assign signature = state_q;
  assign scan_out  = state_q[WIDTH-1];

  // R2
  seed_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> par_out == $past(seed_value));

  // R3
  load_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_load && mode == M_LOAD) |=> par_out == $past(par_in));

  // R4
  scan_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_load && mode == M_SCAN) |=>
      (par_out[0] == $past(scan_in)) && (par_out[WIDTH-1:1] == $past(par_out[WIDTH-2:0])));

  // R6
  gen_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_load && mode == M_GEN) |=> par_out != '0);

  // R8
  comp_stage0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_load && mode == M_COMP) |=> par_out[0] == ($past(scan_out) ^ $past(par_in[0])));

endmodule

// File: tb/bilbo_reg_bench.sv
`timescale 1ns/1ps
module bilbo_reg_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0] mode = 2'b00;
  logic       seed_load = 1'b0;
  logic [7:0] seed_value = '0;
  logic [7:0] par_in = '0;
  logic       scan_in = 1'b0;
  logic [7:0] par_out, signature;
  logic       scan_out;

  logic [1:0] mode4 = 2'b00;
  logic       seed_load4 = 1'b0;
  logic [3:0] seed_value4 = '0;
  logic [3:0] par_out4, signature4;
  logic       scan_out4;

  bilbo_reg #(.WIDTH(8), .TAPS(8'h1D), .DEFAULT_SEED(8'h01)) u_bilbo_reg (
    .clk(clk), .rst_n(rst_n), .mode(mode), .seed_load(seed_load),
    .seed_value(seed_value), .par_in(par_in), .scan_in(scan_in),
    .par_out(par_out), .scan_out(scan_out), .signature(signature));

  bilbo_reg #(.WIDTH(4), .TAPS(4'h3), .DEFAULT_SEED(4'h1)) u_bilbo_reg_d4 (
    .clk(clk), .rst_n(rst_n), .mode(mode4), .seed_load(seed_load4),
    .seed_value(seed_value4), .par_in(4'h0), .scan_in(1'b0),
    .par_out(par_out4), .scan_out(scan_out4), .signature(signature4));

  int checks = 0;
  int errors = 0;
  logic [7:0] model = '0;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] lfsr_step(input logic [7:0] s, input int w, input logic [7:0] taps);
    logic [7:0] mask = 8'((1 << w) - 1);
    logic fb = s[w-1];
    return ((s << 1) ^ (fb ? taps : 8'h00)) & mask;
  endfunction

  function automatic logic [7:0] ref_next(input logic [1:0] m, input logic sl, input logic [7:0] sv,
                                          input logic [7:0] s, input logic [7:0] d, input logic si);
    if (sl) return sv;
    case (m)
      2'b00:   return d;
      2'b01:   return {s[6:0], si};
      2'b10:   return (s == 8'h00) ? 8'h01 : lfsr_step(s, 8, 8'h1D);
      default: return lfsr_step(s, 8, 8'h1D) ^ d;
    endcase
  endfunction

  task automatic step(input string req, input logic [1:0] m, input logic sl, input logic [7:0] sv,
                      input logic [7:0] d, input logic si);
    mode = m; seed_load = sl; seed_value = sv; par_in = d; scan_in = si;
    model = ref_next(m, sl, sv, model, d, si);
    @(negedge clk);
    check(req, par_out, model);
    check("R10", signature, model);
    check("R4", {7'b0, scan_out}, {7'b0, model[7]});
  endtask

  task automatic compact_run(input logic [7:0] stream[16], output logic [7:0] sig);
    step("R2", 2'b11, 1'b1, 8'h00, 8'h00, 1'b0);
    for (int k = 0; k < 16; k++) step("R8", 2'b11, 1'b0, 8'h00, stream[k], 1'b0);
    sig = signature;
  endtask

  initial begin
    #500000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] sa[16], sb[16], sc[16];
    logic [7:0] sig_a, sig_b, sig_c;
    int first;
    logic zero_seen;
    void'($urandom(32'd2024));

    // R1
    repeat (3) @(negedge clk);
    check("R1", par_out, 8'h00);
    check("R1", signature, 8'h00);
    check("R1", {7'b0, scan_out}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    model = par_out;

    step("R3", 2'b00, 1'b0, 8'h00, 8'hA5, 1'b0);
    step("R3", 2'b00, 1'b0, 8'h00, 8'h3C, 1'b0);
    step("R2", 2'b00, 1'b1, 8'h81, 8'hFF, 1'b0);
    step("R2", 2'b01, 1'b1, 8'h42, 8'hFF, 1'b1);
    step("R2", 2'b10, 1'b1, 8'h99, 8'h00, 1'b0);
    step("R2", 2'b11, 1'b1, 8'h17, 8'hFF, 1'b0);

    // R4: shift a pattern in, then observe it serially at scan_out
    for (int k = 0; k < 8; k++) step("R4", 2'b01, 1'b0, 8'h00, 8'h00, k[0] ^ k[2]);
    for (int k = 0; k < 8; k++) begin
      check("R4", {7'b0, scan_out}, {7'b0, k[0] ^ k[2]});
      step("R4", 2'b01, 1'b0, 8'h00, 8'h00, 1'b0);
    end

    // R6: generate mode entered from zero
    step("R3", 2'b00, 1'b0, 8'h00, 8'h00, 1'b0);
    step("R6", 2'b10, 1'b0, 8'h00, 8'h00, 1'b0);
    check("R6", par_out, 8'h01);
    step("R6", 2'b10, 1'b1, 8'h00, 8'h00, 1'b0);
    step("R6", 2'b10, 1'b0, 8'h00, 8'h00, 1'b0);
    check("R6", par_out, 8'h01);
    step("R5", 2'b10, 1'b1, 8'h80, 8'h00, 1'b0);
    step("R5", 2'b10, 1'b0, 8'h00, 8'h00, 1'b0);
    check("R5", par_out, 8'h1D);

    // R7 degree 8
    step("R2", 2'b10, 1'b1, 8'h01, 8'h00, 1'b0);
    mode = 2'b10; seed_load = 1'b0;
    first = 0; zero_seen = 1'b0;
    for (int k = 1; k <= 300; k++) begin
      @(negedge clk);
      if (par_out == 8'h00) zero_seen = 1'b1;
      if (par_out == 8'h01 && first == 0) first = k;
    end
    check("R7", 8'(first), 8'd255);
    check("R7", {7'b0, zero_seen}, 8'h00);
    model = par_out;

    // R7 degree 4
    seed_load4 = 1'b1; seed_value4 = 4'h1; mode4 = 2'b10;
    @(negedge clk);
    seed_load4 = 1'b0;
    check("R2", {4'h0, par_out4}, 8'h01);
    first = 0; zero_seen = 1'b0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (par_out4 == 4'h0) zero_seen = 1'b1;
      if (par_out4 == 4'h1 && first == 0) first = k;
    end
    check("R7", 8'(first), 8'd15);
    check("R7", {7'b0, zero_seen}, 8'h00);
    check("R10", {4'h0, signature4}, {4'h0, par_out4});
    check("R4", {7'b0, scan_out4}, {7'b0, par_out4[3]});

    // R9 linearity
    for (int k = 0; k < 16; k++) begin
      sa[k] = 8'($urandom);
      sb[k] = 8'($urandom);
      sc[k] = sa[k] ^ sb[k];
    end
    compact_run(sa, sig_a);
    compact_run(sb, sig_b);
    compact_run(sc, sig_c);
    check("R9", sig_c, sig_a ^ sig_b);

    // random mode mix against the model
    for (int k = 0; k < 3000; k++) begin
      logic [1:0] m = 2'($urandom);
      logic sl = (($urandom % 8) == 0);
      step(m == 2'b00 ? "R3" : m == 2'b01 ? "R4" : m == 2'b10 ? "R5" : "R8",
           m, sl, 8'($urandom % 4 == 0 ? 0 : $urandom), 8'($urandom), 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule